// File: doc/BRIEF.md
# Aligned Base-Address Window Allocator

This block hands out address windows to bus functions one request at a time. It keeps two running cursors, one for I/O-port space and one for memory space. Each request carries an I/O window size and a memory window size. Each size is either zero or a power of two. For every nonzero size, the block rounds the matching cursor up to a multiple of that size. It then returns the aligned base, the value to write into the function's base-address register, the size mask to report for that register, and the address the host sees once a fixed per-space translation offset is added.

The cursors do not start at the configured bases. They start 64 KiB above them, which leaves the low region free for legacy devices. A request whose window would end past the top of the address range raises an overflow flag. In that case nothing is programmed and neither cursor moves. Results are registered and appear one clock after the request, together with a single-cycle completion pulse.

Top module: `win_alloc`

## Requirements
- R1: After reset, `done`, `ovf`, both write strobes and all value outputs are zero. The I/O cursor starts at `IO_BASE + LEGACY_GAP` and the memory cursor starts at `MEM_BASE + LEGACY_GAP`, where `LEGACY_GAP` defaults to 0x10000.
- R2: `done` is high in the cycle after a cycle with `req` high, and low otherwise. All outputs hold their values while no request is made.
- R3: For a nonzero size S and cursor C, the reported base is ((C-1) | (S-1)) + 1. This base is a multiple of S and is not below C.
- R4: A successful nonzero I/O window sets `io_we`. It returns `io_bar` equal to the aligned base with bit 0 (the I/O space indicator) forced to 1, and `io_mask` equal to S-1.
- R5: A successful nonzero memory window sets `mem_we`. It returns `mem_bar` equal to the aligned base with bit 0 clear, and `mem_mask` equal to S-1.
- R6: `io_host` is the I/O base plus `IO_XLATE`, and `mem_host` is the memory base plus `MEM_XLATE`, both taken modulo 2^AW.
- R7: After a successful request, each cursor equals its aligned base plus its size. A zero size leaves that cursor unaligned and reports the unchanged cursor as its base. It keeps that space's strobe low and reports a zero register value and a zero mask.
- R8: If either window would end above 2^AW, `ovf` is high, both strobes are low, both register values and masks are zero, and neither cursor changes. A window ending exactly at 2^AW is not an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Allocation request, one cycle per request |
| io_size | input | AW | I/O window size, zero or a power of two |
| mem_size | input | AW | Memory window size, zero or a power of two |
| done | output | 1 | Result valid pulse, one cycle after `req` |
| ovf | output | 1 | Request rejected because a window would pass the top |
| io_we | output | 1 | I/O base-address register should be programmed |
| mem_we | output | 1 | Memory base-address register should be programmed |
| io_base | output | AW | Aligned I/O base |
| mem_base | output | AW | Aligned memory base |
| io_bar | output | AW | I/O register value, bit 0 set |
| io_mask | output | AW | I/O size mask |
| mem_bar | output | AW | Memory register value |
| mem_mask | output | AW | Memory size mask |
| io_host | output | AW | Host-visible I/O address |
| mem_host | output | AW | Host-visible memory address |

## Verification
The hardest case to reach is the overflow boundary. A window that ends exactly at 2^AW must be accepted, and the next nonzero window must then be refused without moving either cursor. The stimulus reaches this point from the ports with a half-range memory window that lands exactly on the top, followed by a small memory request. The I/O base of the refused request and of a later accepted request shows that the rejection left the cursors untouched. The reference model tracks both cursors in 64-bit integers, so it also covers a cursor that sits at exactly 2^AW.

// File: rtl/win_alloc.sv
module win_alloc #(
  parameter int AW = 32,
  parameter logic [AW-1:0] IO_BASE    = '0,
  parameter logic [AW-1:0] MEM_BASE   = 'h1000_0000,
  parameter logic [AW-1:0] IO_XLATE   = 'h1f00_0000,
  parameter logic [AW-1:0] MEM_XLATE  = 'h4000_0000,
  parameter logic [AW-1:0] LEGACY_GAP = 'h1_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] io_size,
  input  logic [AW-1:0] mem_size,
  output logic          done,
  output logic          ovf,
  output logic          io_we,
  output logic          mem_we,
  output logic [AW-1:0] io_base,
  output logic [AW-1:0] mem_base,
  output logic [AW-1:0] io_bar,
  output logic [AW-1:0] io_mask,
  output logic [AW-1:0] mem_bar,
  output logic [AW-1:0] mem_mask,
  output logic [AW-1:0] io_host,
  output logic [AW-1:0] mem_host
);
  localparam logic [AW+1:0] ONE       = (AW+2)'(1);
  localparam logic [AW+1:0] TOP       = ONE << AW;
  localparam logic [AW:0]   IO_START  = {1'b0, IO_BASE} + {1'b0, LEGACY_GAP};
  localparam logic [AW:0]   MEM_START = {1'b0, MEM_BASE} + {1'b0, LEGACY_GAP};

  logic [AW:0]   io_cur, mem_cur;
  logic [AW+1:0] io_sz, mem_sz, io_al, mem_al, io_end, mem_end;
  logic          io_zero, mem_zero, io_of, mem_of, bad;

  assign io_sz    = {2'b00, io_size};
  assign mem_sz   = {2'b00, mem_size};
  assign io_zero  = io_size == '0;
  assign mem_zero = mem_size == '0;

  assign io_al  = io_zero  ? {1'b0, io_cur}
                           : ((({1'b0, io_cur} - ONE) | (io_sz - ONE)) + ONE);
  assign mem_al = mem_zero ? {1'b0, mem_cur}
                           : ((({1'b0, mem_cur} - ONE) | (mem_sz - ONE)) + ONE);

  assign io_end  = io_al + io_sz;
  assign mem_end = mem_al + mem_sz;
  assign io_of   = io_end > TOP;
  assign mem_of  = mem_end > TOP;
  assign bad     = io_of | mem_of;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_cur   <= IO_START;
      mem_cur  <= MEM_START;
      done     <= 1'b0;
      ovf      <= 1'b0;
      io_we    <= 1'b0;
      mem_we   <= 1'b0;
      io_base  <= '0;
      mem_base <= '0;
      io_bar   <= '0;
      io_mask  <= '0;
      mem_bar  <= '0;
      mem_mask <= '0;
      io_host  <= '0;
      mem_host <= '0;
    end else begin
      done <= req;
      if (req) begin
        ovf      <= bad;
        io_base  <= io_al[AW-1:0];
        mem_base <= mem_al[AW-1:0];
        io_host  <= io_al[AW-1:0] + IO_XLATE;
        mem_host <= mem_al[AW-1:0] + MEM_XLATE;
        io_we    <= !io_zero && !bad;
        mem_we   <= !mem_zero && !bad;
        io_bar   <= (io_zero || bad) ? '0 : {io_al[AW-1:1], 1'b1};
        io_mask  <= (io_zero || bad) ? '0 : io_size - 1'b1;
        mem_bar  <= (mem_zero || bad) ? '0 : {mem_al[AW-1:1], 1'b0};
        mem_mask <= (mem_zero || bad) ? '0 : mem_size - 1'b1;
        if (!bad) begin
          io_cur  <= io_end[AW:0];
          mem_cur <= mem_end[AW:0];
        end
      end
    end
  end
endmodule

// File: rtl/win_alloc_chk.sv
module win_alloc_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          done,
  input logic          ovf,
  input logic          io_we,
  input logic          mem_we,
  input logic [AW-1:0] io_base,
  input logic [AW-1:0] mem_base,
  input logic [AW-1:0] io_bar,
  input logic [AW-1:0] io_mask,
  input logic [AW-1:0] mem_bar,
  input logic [AW-1:0] mem_mask,
  input logic [AW:0]   io_cur,
  input logic [AW:0]   mem_cur
);
  // R2
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done);

  // R2
  no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !done);

  // R3
  io_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && io_we) |-> ((io_base & io_mask) == '0 && $onehot(io_mask + 1'b1)));

  // R3
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mem_we) |-> ((mem_base & mem_mask) == '0 && $onehot(mem_mask + 1'b1)));

  // R4
  io_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && io_we) |-> (io_bar[0] && io_bar[AW-1:1] == io_base[AW-1:1]));

  // R5
  mem_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mem_we) |-> (!mem_bar[0] && mem_bar == mem_base));

  // R7
  quiet_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !io_we) |-> (io_bar == '0 && io_mask == '0));

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (io_cur == $past(io_cur) && mem_cur == $past(mem_cur) && !io_we && !mem_we));
endmodule

bind win_alloc win_alloc_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .done(done), .ovf(ovf),
  .io_we(io_we), .mem_we(mem_we), .io_base(io_base), .mem_base(mem_base),
  .io_bar(io_bar), .io_mask(io_mask), .mem_bar(mem_bar), .mem_mask(mem_mask),
  .io_cur(io_cur), .mem_cur(mem_cur)
);

// File: tb/sim_win_alloc.sv
`timescale 1ns/1ps
module sim_win_alloc;
  localparam int AW = 32;
  localparam longint IO_BASE   = 64'h0;
  localparam longint MEM_BASE  = 64'h1000_0000;
  localparam longint IO_XL     = 64'h1f00_0000;
  localparam longint MEM_XL    = 64'h4000_0000;
  localparam longint TOP       = 64'h1_0000_0000;
  localparam longint MSK       = 64'hffff_ffff;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] io_size = '0, mem_size = '0;
  logic done, ovf, io_we, mem_we;
  logic [AW-1:0] io_base, mem_base, io_bar, io_mask, mem_bar, mem_mask, io_host, mem_host;

  always #5 clk = ~clk;

  win_alloc #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .io_size(io_size), .mem_size(mem_size),
    .done(done), .ovf(ovf), .io_we(io_we), .mem_we(mem_we),
    .io_base(io_base), .mem_base(mem_base), .io_bar(io_bar), .io_mask(io_mask),
    .mem_bar(mem_bar), .mem_mask(mem_mask), .io_host(io_host), .mem_host(mem_host)
  );

  int checks = 0, fails = 0;
  bit ended = 0;

  longint m_io_cur, m_mem_cur;
  longint e_io_base, e_mem_base, e_io_bar, e_io_mask, e_mem_bar, e_mem_mask, e_io_host, e_mem_host;
  bit e_done, e_ovf, e_io_we, e_mem_we;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(done == e_done, {tag, " done R2"}, longint'(done), longint'(e_done));
    chk(ovf == e_ovf, {tag, " ovf R8"}, longint'(ovf), longint'(e_ovf));
    chk(io_we == e_io_we, {tag, " io_we R4/R7"}, longint'(io_we), longint'(e_io_we));
    chk(mem_we == e_mem_we, {tag, " mem_we R5/R7"}, longint'(mem_we), longint'(e_mem_we));
    chk(io_base == AW'(e_io_base), {tag, " io_base R3"}, longint'(io_base), e_io_base);
    chk(mem_base == AW'(e_mem_base), {tag, " mem_base R3"}, longint'(mem_base), e_mem_base);
    chk(io_bar == AW'(e_io_bar), {tag, " io_bar R4"}, longint'(io_bar), e_io_bar);
    chk(io_mask == AW'(e_io_mask), {tag, " io_mask R4"}, longint'(io_mask), e_io_mask);
    chk(mem_bar == AW'(e_mem_bar), {tag, " mem_bar R5"}, longint'(mem_bar), e_mem_bar);
    chk(mem_mask == AW'(e_mem_mask), {tag, " mem_mask R5"}, longint'(mem_mask), e_mem_mask);
    chk(io_host == AW'(e_io_host), {tag, " io_host R6"}, longint'(io_host), e_io_host);
    chk(mem_host == AW'(e_mem_host), {tag, " mem_host R6"}, longint'(mem_host), e_mem_host);
  endtask

  function automatic longint align(input longint cur, input longint sz);
    if (sz == 0) return cur;
    return (((cur - 1) | (sz - 1)) + 1);
  endfunction

  // Reference: compute expected registered outputs for one request
  task automatic model(input longint isz, input longint msz);
    longint ia, ma;
    bit bad;
    ia  = align(m_io_cur, isz);
    ma  = align(m_mem_cur, msz);
    bad = (ia + isz > TOP) || (ma + msz > TOP);
    e_done     = 1;
    e_ovf      = bad;
    e_io_base  = ia & MSK;
    e_mem_base = ma & MSK;
    e_io_host  = (ia + IO_XL) & MSK;
    e_mem_host = (ma + MEM_XL) & MSK;
    e_io_we    = (isz != 0) && !bad;
    e_mem_we   = (msz != 0) && !bad;
    e_io_bar   = e_io_we ? ((ia & MSK) | 1) : 0;
    e_io_mask  = e_io_we ? isz - 1 : 0;
    e_mem_bar  = e_mem_we ? (ma & MSK) : 0;
    e_mem_mask = e_mem_we ? msz - 1 : 0;
    if (!bad) begin
      m_io_cur  = ia + isz;
      m_mem_cur = ma + msz;
    end
  endtask

  task automatic request(input longint isz, input longint msz, input string tag);
    @(negedge clk);
    req = 1'b1;
    io_size = AW'(isz);
    mem_size = AW'(msz);
    model(isz, msz);
    @(negedge clk);
    req = 1'b0;
    io_size = '0;
    mem_size = '0;
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    e_done = 0;
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    m_io_cur  = IO_BASE + 64'h1_0000;
    m_mem_cur = MEM_BASE + 64'h1_0000;
    e_done = 0; e_ovf = 0; e_io_we = 0; e_mem_we = 0;
    e_io_base = 0; e_mem_base = 0; e_io_bar = 0; e_io_mask = 0;
    e_mem_bar = 0; e_mem_mask = 0; e_io_host = 0; e_mem_host = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    compare_all("reset R1");
    rst_n = 1'b1;
    idle("after reset R1");
    // R1/R3 first request starts 64 KiB above bases
    request(64'h100, 64'h100, "first R1");
    chk(io_base == 32'h0001_0000, "io start R1", longint'(io_base), 64'h1_0000);
    chk(mem_base == 32'h1001_0000, "mem start R1", longint'(mem_base), 64'h1001_0000);
    // R3 rounding up, R7 advance
    request(64'h1000, 64'h2_0000, "round up R3 R7");
    chk(io_base == 32'h0001_1000, "io rounded R3", longint'(io_base), 64'h1_1000);
    // R7 zero sizes
    request(0, 64'h40, "zero io R7");
    request(64'h8, 0, "zero mem R7");
    request(0, 0, "both zero R7");
    // R2 hold while idle
    idle("hold R2");
    idle("hold2 R2");
    // back-to-back requests R2
    request(64'h4, 64'h1000, "b2b a R2");
    request(64'h1, 64'h10, "size one R3");
    // R8 window ending exactly at the top is accepted
    request(64'h10, 64'h8000_0000, "exact top R8");
    chk(ovf == 1'b0, "exact top no ovf R8", longint'(ovf), 0);
    // R8 next memory window overflows; cursors hold
    request(64'h10, 64'h100, "overflow R8");
    chk(ovf == 1'b1, "ovf raised R8", longint'(ovf), 1);
    // R8 io cursor was not moved by the refused request
    request(64'h10, 0, "after ovf R8");
    // R6 larger io window
    request(64'h1_0000, 0, "io big R6");
    idle("final R2");
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!ended) begin
      fails++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule